// File: doc/BRIEF.md
# Banked SRAM card page mapper

This block sits between an 8-bit CPU and a memory-expansion card that carries three memory sockets of up to 512 KB each. The CPU's 64 KB address space is split into eight 8 KB windows, selected by address bits [15:13]. When a user map is active, each window is looked up in a table of byte-wide entries. Each entry names either a card socket and an 8 KB page inside it, or a page of the untouched system memory. When map 0, the built-in system layout, is active, every access passes straight through to system memory.

The lookup table is written through the CPU's I/O space, in a small area of the first socket's window. A write to the control alias of the I/O window chooses which of the 32 user maps is active. The translation path has no registers at all, so a memory access sees its physical address in the same cycle and no wait states are added.

The socket sizes and the behaviour of the third socket (RAM, write-protected ROM or flash) are set by parameters.

Top module: `sram_page_mapper`

## Requirements
- R1: After reset the active map is 0. While map 0 is active, every CPU access sets sys_pass=1 and sys_addr=cpu_addr, and phys_valid=0.
- R2: An I/O write with io_addr[1:0]=3 sets the active map to (io_wdata & 31)+1 from the next clock edge. I/O writes with any other io_addr[1:0] leave the active map unchanged.
- R3: While user map n (1..32) is active, the window w=cpu_addr[15:13] uses table entry index (n-1)*8+w. Entry bits [7:6] give the socket and bits [5:0] give the page. For a card socket, phys_sock is set to the socket and phys_addr={page & mask, cpu_addr[12:0]} (19 bits).
- R4: The page mask of a card socket of size S KB is ((S-1)>>3) in its low 6 bits. A socket of size 0 is unpopulated.
- R5: An entry with socket code 3 sets sys_pass=1 and sys_addr={entry[2:0], cpu_addr[12:0]}. It also sets phys_valid=0, and cpu_rdata then equals sys_rdata.
- R6: An entry that names an unpopulated socket gives phys_valid=0 and phys_we=0, and cpu_rdata reads 8'hFF.
- R7: While io_en=1, the socket is io_addr[1:0], with the value 3 aliased to socket 0. phys_addr is {5'b0, io_addr[15:2]} in this case. An I/O write to socket 0 with io_addr[15:10]=0 stores io_wdata in table entry io_addr[9:2].
- R8: An I/O read from an unpopulated socket returns io_rdata=8'hFF. An I/O read from a populated socket returns io_rdata=mem_rdata.
- R9: When socket 0 is unpopulated, a table write stores 8'hFF instead of the data written.
- R10: With socket 2 in ROM mode (S2_MODE=1), writes to socket 2 give phys_we=0. In flash mode (S2_MODE=2), such writes give phys_we=1 and phys_flash=1.
- R11: The outputs follow cpu_addr and the inputs of the I/O window in the same cycle, with no clock edge in between.
- R12: After reset, every table entry is 8'hFF. An unprogrammed user map therefore sends each window to system page 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU memory address |
| cpu_wr | input | 1 | CPU memory write intent |
| sys_rdata | input | 8 | Read data from system memory |
| mem_rdata | input | 8 | Read data from the card socket addressed |
| io_en | input | 1 | I/O window access this cycle |
| io_wr | input | 1 | I/O access is a write |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| cpu_rdata | output | 8 | Memory read data returned to the CPU |
| io_rdata | output | 8 | I/O read data returned to the CPU |
| sys_pass | output | 1 | Access goes to system memory |
| sys_addr | output | 16 | System memory address |
| phys_sock | output | 2 | Card socket selected |
| phys_addr | output | 19 | Byte address inside the socket |
| phys_valid | output | 1 | Populated card socket selected |
| phys_we | output | 1 | Write permitted to the card socket |
| phys_flash | output | 1 | Access targets socket 2 in flash mode |

## Verification
The bench fills all 256 table entries with a pattern that cycles through all four socket codes. It then activates every user map, using control values with noise in the upper bits, and sweeps all eight windows.

- If the design indexed the table wrongly, or applied the folding mask to the wrong socket, the physical addresses would not match.
- If the design ignored the upper-bit masking, it would pick a map out of range.
- If the design passed data for an empty socket, an unpopulated socket would show valid data or permit writes instead of reading FF.

A second instance, whose first socket is empty, shows that table writes still store FF. Its windows must keep pointing at system page 7 even after the bench writes an entry that would select a populated socket. The bench also probes the I/O alias on address bits [1:0] and the ROM-versus-flash handling of socket 2.

// File: rtl/sram_page_mapper.sv
module sram_page_mapper #(
  parameter int SIZE0_KB = 512,
  parameter int SIZE1_KB = 512,
  parameter int SIZE2_KB = 512,
  parameter int S2_MODE  = 2,
  parameter int NUM_MAPS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  input  logic [7:0]  sys_rdata,
  input  logic [7:0]  mem_rdata,
  input  logic        io_en,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  cpu_rdata,
  output logic [7:0]  io_rdata,
  output logic        sys_pass,
  output logic [15:0] sys_addr,
  output logic [1:0]  phys_sock,
  output logic [18:0] phys_addr,
  output logic        phys_valid,
  output logic        phys_we,
  output logic        phys_flash
);
  localparam int MAPW  = $clog2(NUM_MAPS);
  localparam int ACTW  = $clog2(NUM_MAPS + 1);
  localparam int ENTS  = NUM_MAPS * 8;
  localparam int IDXW  = MAPW + 3;

  function automatic logic [5:0] fold(input int kb);
    return (kb == 0) ? 6'd0 : 6'((kb - 1) >> 3);
  endfunction

  localparam logic [5:0] FOLD0 = fold(SIZE0_KB);
  localparam logic [5:0] FOLD1 = fold(SIZE1_KB);
  localparam logic [5:0] FOLD2 = fold(SIZE2_KB);
  localparam logic [2:0] POP   = {SIZE2_KB != 0, SIZE1_KB != 0, SIZE0_KB != 0};

  logic [ACTW-1:0] act;
  logic [7:0]      tbl [ENTS];

  logic [MAPW-1:0] act_m1;
  logic [7:0]      ent;
  logic [1:0]      io_sock, sock;
  logic [5:0]      fmask;
  logic            sock_pop, io_pop, pass, in_tbl;

  assign act_m1   = MAPW'(act - ACTW'(1));
  assign ent      = tbl[{act_m1, cpu_addr[15:13]}];
  assign io_sock  = (io_addr[1:0] == 2'd3) ? 2'd0 : io_addr[1:0];
  assign sock     = io_en ? io_sock : ent[7:6];
  assign pass     = !io_en && (act == '0 || ent[7:6] == 2'd3);
  assign in_tbl   = (io_addr[15:IDXW+2] == '0) && (io_sock == 2'd0);

  always_comb begin
    case (sock)
      2'd0:    fmask = FOLD0;
      2'd1:    fmask = FOLD1;
      2'd2:    fmask = FOLD2;
      default: fmask = 6'd0;
    endcase
  end

  assign sock_pop = (sock != 2'd3) && POP[sock];
  assign io_pop   = POP[io_sock];

  assign sys_pass   = pass;
  assign sys_addr   = !pass ? 16'h0 :
                      (act == '0) ? cpu_addr : {ent[2:0], cpu_addr[12:0]};
  assign phys_sock  = sock;
  assign phys_addr  = io_en ? {5'b0, io_addr[15:2]} : {ent[5:0] & fmask, cpu_addr[12:0]};
  assign phys_valid = !pass && sock_pop;
  assign phys_we    = phys_valid && (io_en ? io_wr : cpu_wr) &&
                      !(sock == 2'd2 && S2_MODE == 1);
  assign phys_flash = phys_valid && sock == 2'd2 && S2_MODE == 2;
  assign cpu_rdata  = pass ? sys_rdata : (phys_valid ? mem_rdata : 8'hFF);
  assign io_rdata   = io_pop ? mem_rdata : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= '0;
      for (int i = 0; i < ENTS; i++) tbl[i] <= 8'hFF;
    end else if (io_en && io_wr) begin
      if (io_addr[1:0] == 2'd3)
        act <= ACTW'(io_wdata[MAPW-1:0]) + ACTW'(1);
      if (in_tbl)
        tbl[io_addr[IDXW+1:2]] <= POP[0] ? io_wdata : 8'hFF;
    end
  end

  a_r1_map0_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0 && !io_en) |-> (sys_pass && sys_addr == cpu_addr && !phys_valid));

  a_r2_control_select: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && io_wr && io_addr[1:0] == 2'd3) |=>
      (act == ACTW'($past(io_wdata[MAPW-1:0])) + ACTW'(1)));

  a_r5_pass_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pass |-> (!phys_valid && !phys_we && cpu_rdata == sys_rdata));

  a_r6_empty_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en && !sys_pass && !phys_valid) |-> (cpu_rdata == 8'hFF && !phys_we));

  a_r10_rom_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (S2_MODE == 1 && phys_sock == 2'd2) |-> !phys_we);

  a_r8_io_empty_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && !POP[io_sock]) |-> io_rdata == 8'hFF);
endmodule

// File: tb/sim_sram_page_mapper.sv
module sim_sram_page_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_wr = 1'b1;
  logic [7:0] sys_rdata = 8'h3C;
  logic [7:0] mem_rdata = 8'hA7;
  logic io_en = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0;

  logic [7:0] a_crd, a_ird, b_crd, b_ird;
  logic a_pass, a_val, a_we, a_fl, b_pass, b_val, b_we, b_fl;
  logic [15:0] a_sys, b_sys;
  logic [1:0] a_sock, b_sock;
  logic [18:0] a_pa, b_pa;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_page_mapper #(.SIZE0_KB(512), .SIZE1_KB(0), .SIZE2_KB(128), .S2_MODE(1)) u0 (
    .clk, .rst_n, .cpu_addr, .cpu_wr, .sys_rdata, .mem_rdata, .io_en, .io_wr,
    .io_addr, .io_wdata, .cpu_rdata(a_crd), .io_rdata(a_ird), .sys_pass(a_pass),
    .sys_addr(a_sys), .phys_sock(a_sock), .phys_addr(a_pa), .phys_valid(a_val),
    .phys_we(a_we), .phys_flash(a_fl));

  sram_page_mapper #(.SIZE0_KB(0), .SIZE1_KB(256), .SIZE2_KB(512), .S2_MODE(2)) u1 (
    .clk, .rst_n, .cpu_addr, .cpu_wr, .sys_rdata, .mem_rdata, .io_en, .io_wr,
    .io_addr, .io_wdata, .cpu_rdata(b_crd), .io_rdata(b_ird), .sys_pass(b_pass),
    .sys_addr(b_sys), .phys_sock(b_sock), .phys_addr(b_pa), .phys_valid(b_val),
    .phys_we(b_we), .phys_flash(b_fl));

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_en = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_en = 1'b0; io_wr = 1'b0;
  endtask

  function automatic logic [7:0] ent(input int m, input int w);
    return {2'((m + w) % 4), 6'(((m * 8 + w) * 5) % 64)};
  endfunction

  task automatic check_window(input int m, input int w, input string req2);
    logic [7:0] e;
    logic [12:0] low;
    logic [63:0] got, exp;
    e = ent(m, w);
    low = 13'(m * 211 + w * 97);
    cpu_addr = {3'(w), low};
    #2;
    got = {a_pass, a_val, a_we, a_crd, (a_val ? a_pa : 19'h0), a_sys, a_sock};
    case (e[7:6])
      2'd3: exp = {1'b1, 1'b0, 1'b0, 8'h3C, 19'h0, {e[2:0], low}, 2'd3};
      2'd1: exp = {1'b0, 1'b0, 1'b0, 8'hFF, 19'h0, 16'h0, 2'd1};
      2'd0: exp = {1'b0, 1'b1, 1'b1, 8'hA7, {e[5:0], low}, 16'h0, 2'd0};
      default: exp = {1'b0, 1'b1, 1'b0, 8'hA7, {e[5:0] & 6'h0F, low}, 16'h0, 2'd2};
    endcase
    chk(got == exp, (e[7:6] == 2'd3) ? "R5 system page" :
                    (e[7:6] == 2'd1) ? "R6 empty socket" :
                    (e[7:6] == 2'd2) ? "R4/R10 socket2 fold+rom" : "R3 socket0 map", got, exp);
    got = {b_pass, b_sys, b_val};
    exp = {1'b1, {3'b111, low}, 1'b0};
    chk(got == exp, req2, got, exp);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      cpu_addr = {3'(w), 13'(w * 333)};
      #2;
      chk(a_pass && a_sys == cpu_addr && !a_val, "R1 reset passthrough",
          {a_pass, a_sys, a_val}, {1'b1, cpu_addr, 1'b0});
    end

    // R12: unprogrammed map 1 goes to system page 7
    io_write(16'hFC03, 8'h00);
    cpu_addr = 16'h2123; #2;
    chk(a_pass && a_sys == 16'hE123, "R12 reset table FF", {a_pass, a_sys}, {1'b1, 16'hE123});
    // R11: change address without any clock edge
    cpu_addr = 16'h4456; #1;
    chk(a_sys == 16'hE456, "R11 combinational path", a_sys, 16'hE456);

    for (int i = 0; i < 256; i++)
      io_write({6'b0, 8'(i), 2'b00}, ent(i / 8, i % 8));

    for (int m = 0; m < 32; m++) begin
      io_write(16'hFC03, 8'(m) | 8'hE0);
      for (int w = 0; w < 8; w++) check_window(m, w, "R9 empty socket0 stores FF");
    end

    // R2: non-control write leaves map 32 active
    io_write(16'hFC00, 8'h05);
    for (int w = 0; w < 8; w++) check_window(31, w, "R2 non-control write");

    // R9: explicit entry write to socket 1 page 0 on u1 must store FF
    io_write(16'h0000, 8'h40);
    io_write(16'hFC03, 8'h00);
    cpu_addr = 16'h0010; #2;
    chk(b_pass && b_sys == 16'hE010 && !b_val, "R9 FF stored",
        {b_pass, b_sys, b_val}, {1'b1, 16'hE010, 1'b0});
    chk(a_val && a_sock == 2'd1 ? 1'b0 : (!a_val && !a_pass && a_crd == 8'hFF), "R6 rewritten entry",
        {a_val, a_pass, a_crd}, {1'b0, 1'b0, 8'hFF});

    // I/O window reads and writes
    @(negedge clk);
    io_en = 1'b1; io_wr = 1'b0; io_addr = 16'h1234; #2;
    chk(a_sock == 2'd0 && a_pa == 19'h0048D && a_ird == 8'hA7, "R7 io socket0 read",
        {a_sock, a_pa, a_ird}, {2'd0, 19'h0048D, 8'hA7});
    chk(b_ird == 8'hFF, "R8 io empty socket0", b_ird, 8'hFF);
    io_addr = 16'h1235; #2;
    chk(a_ird == 8'hFF && !a_val, "R8 io empty socket1", {a_ird, a_val}, {8'hFF, 1'b0});
    chk(b_ird == 8'hA7 && b_val, "R8 io populated socket1", {b_ird, b_val}, {8'hA7, 1'b1});
    io_addr = 16'h1237; #2;
    chk(a_sock == 2'd0 && a_ird == 8'hA7, "R7 alias 3 to socket0", {a_sock, a_ird}, {2'd0, 8'hA7});
    io_wr = 1'b1; io_addr = 16'hFC06; io_wdata = 8'h11; #2;
    chk(!a_we && a_val && !a_fl, "R10 rom drops write", {a_we, a_val, a_fl}, {1'b0, 1'b1, 1'b0});
    chk(b_we && b_fl, "R10 flash write allowed", {b_we, b_fl}, {1'b1, 1'b1});
    @(negedge clk);
    io_en = 1'b0; io_wr = 1'b0;
    cpu_addr = 16'h0010; #2;
    chk(!a_pass && !a_val && a_sock == 2'd1, "R2 socket2 write keeps map",
        {a_pass, a_val, a_sock}, {1'b0, 1'b0, 2'd1});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule